// File: doc/BRIEF.md
# Preemptible Buffer Memory Bus Arbiter

This block decides who drives a shared buffer memory bus: the internal memory controller or an external node processor. The internal side raises either a normal access request or an urgent (preempting) access request together with an address. The processor raises a bus request and owns the bus for as long as the arbiter holds its acknowledge high. While the processor owns the bus, the address and control output enables are low, so the pads can be tri-stated.

An urgent internal request takes the bus back from the processor. The acknowledge falls, and the arbiter then keeps its own enables low for a fixed release window. This gives the processor time to stop driving. Only after that window does the internal side run its access. Every internal access lasts exactly two clock cycles, with the strobe high and a latched address held in both. When nobody holds a grant, the arbiter keeps driving the last address with the strobe low. A processor that has been preempted receives no new grant until its request has been seen low.

Top module: `buf_mem_arbiter`

## Requirements
- R1: While `rst_n` is low, the outputs are forced at once to `np_ack`=0, `strobe`=0, `addr_oe`=1, `ctl_oe`=1 and `addr_out`=0, whatever the state was.
- R2: An internal access holds `strobe` high for exactly two consecutive cycles, then drops it for at least one cycle.
- R3: While `np_ack` is high, `addr_oe` and `ctl_oe` are low and `strobe` is low. Outside of a grant and its release window, both enables are high.
- R4: If `pre_req` is high during a grant, `np_ack` is low in the cycle after, even if `np_req` is still high.
- R5: After `np_ack` falls, for any reason, both enables and `strobe` stay low for `RELEASE_CYC` (default 2) cycles, and no new grant is made in that window.
- R6: After a preemption, `np_ack` is not raised again until `np_req` has been sampled low in at least one cycle.
- R7: A processor request that arrives during an internal access gets no acknowledge until that access has ended.
- R8: When no grant is held and no access is running, `addr_oe` stays high with `strobe` low, and `addr_out` keeps the last latched address.
- R9: `addr_out` carries the `int_addr` value sampled when the access was accepted, and it stays unchanged in both cycles of the access even if `int_addr` changes.
- R10: At an arbitration point the order is: `pre_req` first, then `np_req` (if the processor is allowed a grant), then `int_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| np_req | input | 1 | Processor bus request |
| pre_req | input | 1 | Urgent internal access request; preempts the processor |
| int_req | input | 1 | Normal internal access request; ranks below the processor |
| int_addr | input | ADDR_W | Address for the internal access |
| np_ack | output | 1 | Processor owns the bus |
| strobe | output | 1 | Internal access in progress |
| addr_out | output | ADDR_W | Buffer memory address |
| addr_oe | output | 1 | Output enable for the address pads |
| ctl_oe | output | 1 | Output enable for the control pads |

## Verification
The bench preempts a live grant while the processor keeps its request high. A design that does not remember the preemption would hand the bus straight back after the window, and a design that skips the window would raise its enables in the very cycle the acknowledge falls. It changes `int_addr` during the second cycle of an access, which would expose an address that is routed through instead of latched. It also raises the processor request during an access and checks that the access finishes first. Ties between all three requesters confirm the priority order. A reset during a grant must clear the acknowledge at once, without waiting for a clock edge.

// File: rtl/bma_pkg.sv
package bma_pkg;
  typedef enum logic [2:0] {
    ST_PARK = 3'd0,
    ST_ACC1 = 3'd1,
    ST_ACC2 = 3'd2,
    ST_NPOW = 3'd3,
    ST_RELW = 3'd4
  } bma_state_e;
endpackage

// File: rtl/bma_rel_timer.sv
module bma_rel_timer #(
  parameter int RELEASE_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = (RELEASE_CYC > 2) ? $clog2(RELEASE_CYC) : 1;
  localparam logic [CW-1:0] LOADV = CW'(RELEASE_CYC - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done   = (cnt_q == '0);
  assign cnt_en = load | (run & ~done);

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = LOADV;
    else if (run) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/bma_addr_hold.sv
module bma_addr_hold #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '0;
    else if (cap) addr_q <= addr_in;
  end
endmodule

// File: rtl/bma_fsm.sv
module bma_fsm
  import bma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic np_req,
  input  logic pre_req,
  input  logic int_req,
  input  logic rel_done,
  output logic cap,
  output logic rel_load,
  output logic rel_run,
  output bma_state_e state
);
  bma_state_e state_d, pick;
  logic       hold_low_q, hold_low_d;

  // arbitration order: urgent internal, processor, normal internal
  always_comb begin
    if (pre_req)                     pick = ST_ACC1;
    else if (np_req && !hold_low_q)  pick = ST_NPOW;
    else if (int_req)                pick = ST_ACC1;
    else                             pick = ST_PARK;
  end

  always_comb begin
    state_d = state;
    unique case (state)
      ST_PARK: state_d = pick;
      ST_ACC1: state_d = ST_ACC2;
      ST_ACC2: state_d = ST_PARK;
      ST_NPOW: if (pre_req || !np_req) state_d = ST_RELW;
      ST_RELW: if (rel_done) state_d = pick;
      default: state_d = ST_PARK;
    endcase
  end

  assign cap      = (state_d == ST_ACC1);
  assign rel_load = (state == ST_NPOW) && (state_d == ST_RELW);
  assign rel_run  = (state == ST_RELW);

  // a preempted processor must drop its request once before regrant
  always_comb begin
    hold_low_d = hold_low_q;
    if (state == ST_NPOW && pre_req) hold_low_d = 1'b1;
    else if (!np_req)                hold_low_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_PARK;
      hold_low_q <= 1'b0;
    end else begin
      state      <= state_d;
      hold_low_q <= hold_low_d;
    end
  end
endmodule

// File: rtl/buf_mem_arbiter.sv
module buf_mem_arbiter
  import bma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int RELEASE_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              np_req,
  input  logic              pre_req,
  input  logic              int_req,
  input  logic [ADDR_W-1:0] int_addr,
  output logic              np_ack,
  output logic              strobe,
  output logic [ADDR_W-1:0] addr_out,
  output logic              addr_oe,
  output logic              ctl_oe
);
  bma_state_e state;
  logic cap, rel_load, rel_run, rel_done;

  bma_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .np_req(np_req), .pre_req(pre_req),
    .int_req(int_req), .rel_done(rel_done), .cap(cap),
    .rel_load(rel_load), .rel_run(rel_run), .state(state)
  );

  bma_rel_timer #(.RELEASE_CYC(RELEASE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(rel_load), .run(rel_run), .done(rel_done)
  );

  bma_addr_hold #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .cap(cap), .addr_in(int_addr), .addr_q(addr_out)
  );

  logic drive;
  assign drive   = (state != ST_NPOW) && (state != ST_RELW);
  assign np_ack  = (state == ST_NPOW);
  assign strobe  = (state == ST_ACC1) || (state == ST_ACC2);
  assign addr_oe = drive;
  assign ctl_oe  = drive;
endmodule

// File: rtl/bma_checker.sv
module bma_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              np_req,
  input logic              pre_req,
  input logic              np_ack,
  input logic              strobe,
  input logic [ADDR_W-1:0] addr_out,
  input logic              addr_oe,
  input logic              ctl_oe
);
  assert_grant_tristate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    np_ack |-> (!addr_oe && !ctl_oe && !strobe));

  assert_two_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |=> strobe);

  assert_no_third_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |=> !strobe);

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe) |=> $stable(addr_out));

  assert_preempt_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (np_ack && pre_req) |=> !np_ack);

  assert_release_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(np_ack) |-> (!addr_oe && !ctl_oe && !strobe));

  assert_release_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(np_ack) |=> (!addr_oe && !ctl_oe && !strobe && !np_ack));

  assert_access_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !np_ack);
endmodule

bind buf_mem_arbiter bma_checker #(.ADDR_W(ADDR_W)) u_bma_chk (
  .clk(clk), .rst_n(rst_n), .np_req(np_req), .pre_req(pre_req),
  .np_ack(np_ack), .strobe(strobe), .addr_out(addr_out),
  .addr_oe(addr_oe), .ctl_oe(ctl_oe)
);

// File: tb/test_buf_mem_arbiter.sv
`timescale 1ns/1ps
module test_buf_mem_arbiter;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic np_req, pre_req, int_req;
  logic [AW-1:0] int_addr;
  logic np_ack, strobe, addr_oe, ctl_oe;
  logic [AW-1:0] addr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  buf_mem_arbiter #(.ADDR_W(AW), .RELEASE_CYC(2)) i_buf_mem_arbiter (
    .clk(clk), .rst_n(rst_n), .np_req(np_req), .pre_req(pre_req),
    .int_req(int_req), .int_addr(int_addr), .np_ack(np_ack),
    .strobe(strobe), .addr_out(addr_out), .addr_oe(addr_oe), .ctl_oe(ctl_oe)
  );

  typedef struct packed {
    logic pre, np, ir;
    logic [15:0] a;
    logic e_ack, e_stb, e_oe, chk_a;
    logic [15:0] e_a;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t VEC [NV] = '{
    {1'b0,1'b0,1'b1,16'h1111, 1'b0,1'b1,1'b1,1'b1,16'h1111,4'd2},  // 0 R2 access start
    {1'b0,1'b0,1'b0,16'h2222, 1'b0,1'b1,1'b1,1'b1,16'h1111,4'd9},  // 1 R9 addr held
    {1'b0,1'b0,1'b0,16'h2222, 1'b0,1'b0,1'b1,1'b1,16'h1111,4'd8},  // 2 R8 parked
    {1'b0,1'b1,1'b0,16'h2222, 1'b1,1'b0,1'b0,1'b0,16'h0000,4'd3},  // 3 R3 grant
    {1'b0,1'b1,1'b1,16'h2222, 1'b1,1'b0,1'b0,1'b0,16'h0000,4'd10}, // 4 R10 normal below np
    {1'b1,1'b1,1'b0,16'h3333, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd4},  // 5 R4 preempt
    {1'b1,1'b1,1'b0,16'h3333, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 6 R5 window 2
    {1'b1,1'b1,1'b0,16'h3333, 1'b0,1'b1,1'b1,1'b1,16'h3333,4'd5},  // 7 R5 retake
    {1'b0,1'b1,1'b0,16'h3333, 1'b0,1'b1,1'b1,1'b1,16'h3333,4'd2},  // 8 R2
    {1'b0,1'b1,1'b0,16'h3333, 1'b0,1'b0,1'b1,1'b0,16'h0000,4'd6},  // 9 R6 no regrant
    {1'b0,1'b0,1'b0,16'h3333, 1'b0,1'b0,1'b1,1'b0,16'h0000,4'd6},  // 10 R6 req low
    {1'b0,1'b1,1'b0,16'h3333, 1'b1,1'b0,1'b0,1'b0,16'h0000,4'd6},  // 11 R6 regrant
    {1'b0,1'b0,1'b0,16'h3333, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 12 R5 voluntary
    {1'b0,1'b1,1'b0,16'h3333, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 13 R5 no grant in window
    {1'b0,1'b1,1'b0,16'h3333, 1'b1,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 14 R5 grant after
    {1'b0,1'b0,1'b0,16'h3333, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 15
    {1'b0,1'b0,1'b0,16'h3333, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 16
    {1'b0,1'b0,1'b1,16'h4444, 1'b0,1'b1,1'b1,1'b1,16'h4444,4'd2},  // 17 R2
    {1'b0,1'b1,1'b0,16'h4444, 1'b0,1'b1,1'b1,1'b1,16'h4444,4'd7},  // 18 R7 finish access
    {1'b0,1'b1,1'b0,16'h4444, 1'b0,1'b0,1'b1,1'b0,16'h0000,4'd7},  // 19 R7
    {1'b0,1'b1,1'b0,16'h4444, 1'b1,1'b0,1'b0,1'b0,16'h0000,4'd7},  // 20 R7 grant
    {1'b0,1'b0,1'b0,16'h4444, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 21
    {1'b0,1'b0,1'b0,16'h4444, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 22
    {1'b0,1'b0,1'b0,16'h4444, 1'b0,1'b0,1'b1,1'b1,16'h4444,4'd8},  // 23 R8
    {1'b0,1'b1,1'b1,16'h5555, 1'b1,1'b0,1'b0,1'b0,16'h0000,4'd10}, // 24 R10 np beats normal
    {1'b0,1'b0,1'b1,16'h5555, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 25
    {1'b0,1'b0,1'b1,16'h5555, 1'b0,1'b0,1'b0,1'b0,16'h0000,4'd5},  // 26
    {1'b0,1'b0,1'b1,16'h5555, 1'b0,1'b1,1'b1,1'b1,16'h5555,4'd2},  // 27
    {1'b0,1'b0,1'b0,16'h5555, 1'b0,1'b1,1'b1,1'b1,16'h5555,4'd2},  // 28
    {1'b0,1'b0,1'b0,16'h5555, 1'b0,1'b0,1'b1,1'b1,16'h5555,4'd2},  // 29 R2 ends
    {1'b1,1'b1,1'b0,16'h6666, 1'b0,1'b1,1'b1,1'b1,16'h6666,4'd10}, // 30 R10 pre beats np
    {1'b0,1'b1,1'b0,16'h6666, 1'b0,1'b1,1'b1,1'b1,16'h6666,4'd10}, // 31
    {1'b0,1'b1,1'b0,16'h6666, 1'b0,1'b0,1'b1,1'b0,16'h0000,4'd10}, // 32
    {1'b0,1'b1,1'b0,16'h6666, 1'b1,1'b0,1'b0,1'b0,16'h0000,4'd3}   // 33 R3
  };

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input int rq, input logic ea, input logic es, input logic eo,
                            input logic ca, input logic [AW-1:0] eadr);
    string t;
    t = $sformatf("R%0d", rq);
    check({t, " np_ack"}, AW'(np_ack), AW'(ea));
    check({t, " strobe"}, AW'(strobe), AW'(es));
    check({t, " addr_oe"}, AW'(addr_oe), AW'(eo));
    check({t, " ctl_oe"}, AW'(ctl_oe), AW'(eo));
    if (ca) check({t, " addr_out"}, addr_out, eadr);
  endtask

  initial begin
    #(4 * 20000);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; np_req = 1'b0; pre_req = 1'b0; int_req = 1'b0; int_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    check_outs(1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000); // R1 reset state
    rst_n = 1'b1;
    @(posedge clk); #1;
    check_outs(8, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000); // R8 idle drives

    for (int i = 0; i < NV; i++) begin
      pre_req = VEC[i].pre; np_req = VEC[i].np; int_req = VEC[i].ir; int_addr = VEC[i].a;
      @(posedge clk); #1;
      check_outs(int'(VEC[i].req), VEC[i].e_ack, VEC[i].e_stb, VEC[i].e_oe, VEC[i].chk_a, VEC[i].e_a);
    end

    // R1: asynchronous reset during a grant clears outputs before any edge
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check_outs(1, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000);
    np_req = 1'b0; pre_req = 1'b0; int_req = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R6: preempt, request drops inside the window, grant returns after it
    np_req = 1'b1;
    @(posedge clk); #1;
    check_outs(3, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);
    pre_req = 1'b1; int_addr = 16'h7777;
    @(posedge clk); #1;
    check_outs(4, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    pre_req = 1'b0; np_req = 1'b0;
    @(posedge clk); #1;
    check_outs(5, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000);
    np_req = 1'b1;
    @(posedge clk); #1;
    check_outs(6, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000);

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule